// File: doc/BRIEF.md
# Pointer-Driven ROM Bank Controller

This block sits between an 8-bit CPU with a 13-bit address bus and a 64K cartridge ROM. The CPU sees a 4K ROM window at $1000-$1FFF. The controller watches every bus access, both address and data, and keeps three pieces of state: a section bit, a 3-bit primary bank and a 3-bit temporary bank. From this state and the window offset it forms the 16-bit ROM address.

The upper quarter of the window ($1C00-$1FFF) is meant to hold code. Any access there first copies the primary bank into the temporary bank and is then served from that bank. The lower three quarters ($1000-$1BFF) are always served from the temporary bank.

When the primary bank is in the lower half (0 to 3), any access to zero-page addresses $0080-$00BF loads the temporary bank from the top three data bits. As a result, the high byte of a zero-page pointer that an indirect-indexed load fetches picks the data bank for that one load. Each pointer can therefore reach its own bank with no explicit switch.

Two address patterns in the non-ROM space act as commands:
- The immediate-select pattern sets the section bit and both bank registers at once.
- The primary-only pattern loads the primary bank alone. The new bank takes effect at the next upper-quarter access.

Top module: `ptr_bank_ctrl`

## Requirements
- R1: The ROM address is {section, bank[2:0], A11..A0}. Its low 12 bits always equal the CPU address bits 11..0.
- R2: A strobed access in $1C00-$1FFF copies the primary bank into the temporary bank. The same access is served from the copied bank.
- R3: A strobed access in $1000-$1BFF is served from the temporary bank. The primary bank has no effect on it.
- R4: A strobed access matching the 13-bit pattern 0 1 1 x x n3 n2 n1 n0 1 x x x (for example $0FnF) loads the section bit with n3 and loads both bank registers with n2..n0.
- R5: A strobed access matching 0 0 1 x x x n2 n1 n0 1 x x x (for example $07nF) loads only the primary bank with n2..n0. Accesses to $1000-$1BFF keep their bank until the next $1C00-$1FFF access.
- R6: While the primary bank is 0 to 3, a strobed access with A12..A6 = 0000010 ($0080-$00BF) loads the temporary bank from data bits 7..5. Accesses just outside that range ($007F, $00C0) change nothing.
- R7: While the primary bank is 4 to 7, accesses in $0080-$00BF leave the temporary bank unchanged.
- R8: When the bus strobe is low, no register changes, whatever the address.
- R9: Reset clears the section bit and both bank registers, so the first window access maps to section 0, bank 0. Reset also takes effect when asserted in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_strobe | input | 1 | Marks a valid bus cycle with address and data stable |
| cpu_addr | input | 13 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| rom_addr | output | 16 | ROM address {section, bank, offset} |

## Verification
The hardest state to reach from the ports is one where the primary and temporary banks differ, so that the served bank reveals which register was used. The stimulus gets there in two ways: a zero-page data latch under a low primary bank, and a primary-only load that has not yet been committed. It then probes the lower window, the upper window and the lower window again, showing the deferred copy happening within the same access. Pointer loads are also issued with the primary bank in the upper half, where the latch must be refused, and at $007F and $00C0, just beside the latch range.

// File: rtl/ptr_bank_pkg.sv
package ptr_bank_pkg;

  localparam int BANK_W = 3;

  typedef enum logic [2:0] {
    ACC_OTHER,
    ACC_WIN_LO,
    ACC_WIN_HI,
    ACC_IMM,
    ACC_PRI,
    ACC_ZP
  } acc_kind_e;

  typedef struct packed {
    logic              sect;
    logic [BANK_W-1:0] prim;
    logic [BANK_W-1:0] temp;
  } bank_state_t;

endpackage

// File: rtl/ptr_bank_rst_sync.sv
module ptr_bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ptr_bank_decode.sv
module ptr_bank_decode
  import ptr_bank_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [BANK_W:0]   sel_nib
);

  localparam int A_TOP   = ADDR_W - 1;
  localparam int A_QHI   = ADDR_W - 2;
  localparam int A_QLO   = ADDR_W - 3;
  localparam int STROBE_BIT = 3;
  localparam int NIB_LO  = 4;
  localparam int ZP_LO   = 6;
  localparam logic [A_QHI-ZP_LO:0] ZP_TAG = (A_QHI - ZP_LO + 1)'(2);

  logic [1:0] quarter;

  always_comb begin
    quarter = {addr[A_QHI], addr[A_QLO]};
    kind    = ACC_OTHER;
    sel_nib = '0;
    if (addr[A_TOP]) begin
      kind = (quarter == 2'b11) ? ACC_WIN_HI : ACC_WIN_LO;
    end else if (quarter == 2'b11 && addr[STROBE_BIT]) begin
      kind    = ACC_IMM;
      sel_nib = addr[NIB_LO +: BANK_W+1];
    end else if (quarter == 2'b01 && addr[STROBE_BIT]) begin
      kind    = ACC_PRI;
      sel_nib = {1'b0, addr[NIB_LO +: BANK_W]};
    end else if (addr[A_QHI:ZP_LO] == ZP_TAG) begin
      kind = ACC_ZP;
    end
  end

endmodule

// File: rtl/ptr_bank_regs.sv
module ptr_bank_regs
  import ptr_bank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  acc_kind_e         kind,
  input  logic [BANK_W:0]   sel_nib,
  input  logic [DATA_W-1:0] data,
  output bank_state_t       cur,
  output bank_state_t       nxt
);

  localparam int LATCH_LIMIT = 2 ** (BANK_W - 1);

  logic zp_allowed;

  always_comb begin
    zp_allowed = (int'(cur.prim) < LATCH_LIMIT);
    nxt        = cur;
    if (strobe) begin
      unique case (kind)
        ACC_WIN_HI: nxt.temp = cur.prim;
        ACC_IMM: begin
          nxt.sect = sel_nib[BANK_W];
          nxt.prim = sel_nib[BANK_W-1:0];
          nxt.temp = sel_nib[BANK_W-1:0];
        end
        ACC_PRI:    nxt.prim = sel_nib[BANK_W-1:0];
        ACC_ZP:     if (zp_allowed) nxt.temp = data[DATA_W-1 -: BANK_W];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (strobe) cur <= nxt;
  end

  // R4
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_IMM) |=>
      (cur.sect == $past(sel_nib[BANK_W]) &&
       cur.prim == $past(sel_nib[BANK_W-1:0]) &&
       cur.temp == $past(sel_nib[BANK_W-1:0])));

  // R5
  prim_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_PRI) |=>
      (cur.prim == $past(sel_nib[BANK_W-1:0]) && $stable(cur.temp) && $stable(cur.sect)));

  // R7
  zp_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_ZP && cur.prim[BANK_W-1]) |=> $stable(cur.temp));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cur));

  // R2
  hi_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_WIN_HI) |=> (cur.temp == $past(cur.prim) && $stable(cur.prim)));

endmodule

// File: rtl/ptr_bank_addr_form.sv
module ptr_bank_addr_form
  import ptr_bank_pkg::*;
#(
  parameter int OFFS_W = 12,
  parameter int ROMA_W = 1 + BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  acc_kind_e         kind,
  input  bank_state_t       cur,
  input  bank_state_t       nxt,
  input  logic [OFFS_W-1:0] offset,
  output logic [ROMA_W-1:0] rom_addr
);

  always_comb begin
    rom_addr = {nxt.sect, nxt.temp, offset};
  end

  // R3
  lo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_WIN_LO) |-> (rom_addr[OFFS_W +: BANK_W] == cur.temp));

  // R2
  hi_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACC_WIN_HI) |-> (rom_addr[OFFS_W +: BANK_W] == cur.prim));

endmodule

// File: rtl/ptr_bank_ctrl.sv
module ptr_bank_ctrl
  import ptr_bank_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int OFFS_W = 12,
  parameter int ROMA_W = 1 + BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [ROMA_W-1:0] rom_addr
);

  logic            rst_n_sync;
  acc_kind_e       kind;
  logic [BANK_W:0] sel_nib;
  bank_state_t     cur;
  bank_state_t     nxt;

  ptr_bank_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ptr_bank_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr    (cpu_addr),
    .kind    (kind),
    .sel_nib (sel_nib)
  );

  ptr_bank_regs #(.DATA_W(DATA_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .strobe  (bus_strobe),
    .kind    (kind),
    .sel_nib (sel_nib),
    .data    (cpu_data),
    .cur     (cur),
    .nxt     (nxt)
  );

  ptr_bank_addr_form #(.OFFS_W(OFFS_W), .ROMA_W(ROMA_W)) i_form (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .strobe   (bus_strobe),
    .kind     (kind),
    .cur      (cur),
    .nxt      (nxt),
    .offset   (cpu_addr[OFFS_W-1:0]),
    .rom_addr (rom_addr)
  );

endmodule

// File: tb/test_ptr_bank_ctrl.sv
module test_ptr_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [15:0] rom_addr;
  logic [7:0]  rom_q;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_bank_ctrl i_ptr_bank_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_strobe (bus_strobe),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .rom_addr   (rom_addr)
  );

  // ROM model: every byte holds its own {section, bank} in the low nibble
  assign rom_q = {4'hA, rom_addr[15:12]};

  // fields: chk, strobe, addr[13], data[8], expected bank[4], req[4]
  localparam int NV = 35;
  localparam logic [30:0] VECS [NV] = '{
    {1'b1, 1'b1, 13'h1C00, 8'h00, 4'h0, 4'd2},  // R2 after reset
    {1'b0, 1'b1, 13'h0F5F, 8'h00, 4'h0, 4'd4},  // R4 select s0 b5
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h5, 4'd4},
    {1'b1, 1'b1, 13'h1C10, 8'h00, 4'h5, 4'd2},
    {1'b0, 1'b1, 13'h0FDF, 8'h00, 4'h0, 4'd4},  // R4 select s1 b5
    {1'b1, 1'b1, 13'h1FFF, 8'h00, 4'hD, 4'd4},
    {1'b0, 1'b1, 13'h0F0F, 8'h00, 4'h0, 4'd4},
    {1'b0, 1'b1, 13'h0088, 8'hE0, 4'h0, 4'd6},  // R6 pointer high byte 7
    {1'b1, 1'b1, 13'h1234, 8'h00, 4'h7, 4'd6},
    {1'b1, 1'b1, 13'h1C00, 8'h00, 4'h0, 4'd2},
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h0, 4'd3},
    {1'b0, 1'b1, 13'h007F, 8'hE0, 4'h0, 4'd6},  // just below latch range
    {1'b0, 1'b1, 13'h00C0, 8'hFF, 4'h0, 4'd6},  // just above latch range
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h0, 4'd6},
    {1'b0, 1'b1, 13'h074F, 8'h00, 4'h0, 4'd5},  // R5 primary 4 only
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h0, 4'd5},
    {1'b1, 1'b1, 13'h1C00, 8'h00, 4'h4, 4'd5},
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h4, 4'd3},
    {1'b0, 1'b1, 13'h0090, 8'h20, 4'h0, 4'd7},  // R7 latch refused
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h4, 4'd7},
    {1'b0, 1'b1, 13'h070F, 8'h00, 4'h0, 4'd5},
    {1'b1, 1'b1, 13'h1C00, 8'h00, 4'h0, 4'd2},
    {1'b0, 1'b1, 13'h00A0, 8'h60, 4'h0, 4'd6},
    {1'b1, 1'b1, 13'h1800, 8'h00, 4'h3, 4'd6},
    {1'b1, 1'b1, 13'h1BFF, 8'h00, 4'h3, 4'd3},
    {1'b0, 1'b1, 13'h00BF, 8'hA0, 4'h0, 4'd6},
    {1'b1, 1'b1, 13'h1400, 8'h00, 4'h5, 4'd6},
    {1'b0, 1'b0, 13'h0F7F, 8'h00, 4'h0, 4'd8},  // R8 no strobe
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h5, 4'd8},
    {1'b0, 1'b1, 13'h0FBF, 8'h00, 4'h0, 4'd4},
    {1'b1, 1'b1, 13'h1C00, 8'h00, 4'hB, 4'd4},
    {1'b0, 1'b1, 13'h0080, 8'hC0, 4'h0, 4'd6},
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'hE, 4'd6},
    {1'b0, 1'b1, 13'h0E3F, 8'h00, 4'h0, 4'd4},  // A9/A8 ignored
    {1'b1, 1'b1, 13'h1000, 8'h00, 4'h3, 4'd4}
  };

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic check(input logic [3:0] exp_bank, input logic [11:0] exp_offs, input int req);
    vectors++;
    if (rom_q[3:0] !== exp_bank) begin
      misses++;
      $display("FAIL R%0d addr %h: bank got %h expected %h", req, cpu_addr, rom_q[3:0], exp_bank);
    end
    vectors++;
    if (rom_addr[11:0] !== exp_offs) begin
      misses++;
      $display("FAIL R1 addr %h: offset got %h expected %h", cpu_addr, rom_addr[11:0], exp_offs);
    end
  endtask

  task automatic apply(input logic s, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_strobe = s;
    cpu_addr   = a;
    cpu_data   = d;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    vectors++;
    misses++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R9 reset state
    apply(1'b0, 13'h1000, 8'h00);
    check(4'h0, 12'h000, 9);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][29], VECS[i][28:16], VECS[i][15:8]);
      if (VECS[i][30]) check(VECS[i][7:4], VECS[i][27:16], int'(VECS[i][3:0]));
    end

    // R9 mid-run reset, state is s0 b3 here
    apply(1'b0, 13'h1ABC, 8'h00);
    rst_n = 1'b0;
    #1;
    check(4'h0, 12'hABC, 9);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(1'b1, 13'h1FC3, 8'h00);
    check(4'h0, 12'hFC3, 9);

    // R2 same-access copy after a deferred primary load of 6
    apply(1'b1, 13'h076F, 8'h00);
    apply(1'b1, 13'h1321, 8'h00);
    check(4'h0, 12'h321, 5);
    apply(1'b1, 13'h1D55, 8'h00);
    check(4'h6, 12'hD55, 2);
    apply(1'b1, 13'h1321, 8'h00);
    check(4'h6, 12'h321, 3);
    bus_strobe = 1'b0;

    report();
  end

endmodule